// File: doc/BRIEF.md
# Per-Pixel Display Mode Mapper

This block sits in a display back end, between the frame-buffer scan-out and the colour lookup stage. Each stored pixel is 24 bits wide. It arrives together with a display ID that says which screen region, and therefore which pixel format, it belongs to. The display ID selects one entry of a small table of mode words. That entry decides how the 24 bits are read:

- as an 8-bit colour index, taken from the low or high byte;
- as one 24-bit true-colour value;
- as one half of a pair of 12-bit RGB buffers;
- as blank.

For index formats the entry also chooses which colormap the index goes to.

Software loads the table through a single-cycle write port, normally once at start-up. A typical setup is ID 1 for single-buffered colour index, ID 2 for double-buffered colour index and ID 3 for single-buffered RGB. Display swaps later flip the front-buffer bit of an entry. The pipeline has two stages, mode lookup and then format and output. The output carries either a colormap index with a colormap select, or a direct 24-bit RGB value, and a flag that tells which of the two it is.

Top module: `pixel_mode_mapper`

## Requirements
- R1: While reset is held and after it is released, out_valid is low, and every table entry reads as format 0 with front bit 0 and colormap 0 until it is written.
- R2: A pixel accepted with pix_valid high produces out_valid high exactly two clock edges later. A cycle with pix_valid low produces out_valid low two edges later.
- R3: When cfg_we is high, cfg_mode is stored in entry cfg_id. Its fields are format in bits [2:0], front select in bit [3] and colormap select in bits [6:4]. Each pixel uses the entry named by its pix_id, and all 32 IDs (0 to 31) are addressable.
- R4: A pixel presented in the same cycle as a write to its ID uses the entry's old contents. A pixel presented one cycle later uses the new contents.
- R5: Format 0 (single colour index) outputs index = pixel[7:0] and the entry's colormap select. The front bit has no effect.
- R6: Format 1 (double colour index) outputs index = pixel[7:0] when the front bit is 0 and pixel[15:8] when it is 1, with the entry's colormap select.
- R7: Format 2 (true colour) outputs rgb = pixel unchanged, with red in [23:16]. The front bit has no effect.
- R8: Format 3 (double 12-bit RGB) takes the 12-bit half pixel[11:0] when the front bit is 0 and pixel[23:12] when it is 1. Within that half, red is [11:8], green [7:4] and blue [3:0]. Each 4-bit channel becomes the output byte {c,c}, and the bytes are ordered red, green, blue from the top.
- R9: Formats 4 to 7 output blank: is_rgb high and rgb zero.
- R10: When out_is_rgb is high, out_index and out_cmap are zero. When it is low, out_rgb is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Mode table write strobe |
| cfg_id | input | 5 | Table entry to write |
| cfg_mode | input | 7 | Mode word {cmap[6:4], front[3], format[2:0]} |
| pix_valid | input | 1 | Pixel input is valid |
| pix_id | input | 5 | Display ID of the pixel |
| pix_data | input | 24 | Stored pixel word |
| out_valid | output | 1 | Output pixel is valid |
| out_is_rgb | output | 1 | 1: out_rgb is the result; 0: out_index/out_cmap are |
| out_index | output | 8 | Colormap index |
| out_cmap | output | 3 | Colormap select |
| out_rgb | output | 24 | Direct RGB value |

## Verification
Directed pixels use byte patterns with distinct nibbles, such as 0xABCDEF and 0x123456. With these, picking the wrong byte, the wrong 12-bit half or the wrong channel order gives a visibly different output for every format, and flipping the front bit on single-buffered formats shows that the bit is ignored. A write and a pixel to the same ID in one cycle, followed by a second pixel, separate old-entry from new-entry use. Random traffic then mixes random mode words, including reserved formats, with writes that often hit the ID being displayed in that cycle, and with gaps in pix_valid. Every result is compared against a bench model of the table with a two-cycle delay.

// File: rtl/pixel_mode_mapper.sv
module pixel_mode_mapper #(
  parameter int ID_W   = 5,
  parameter int CMAP_W = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_we,
  input  logic [ID_W-1:0]       cfg_id,
  input  logic [CMAP_W+3:0]     cfg_mode,
  input  logic                  pix_valid,
  input  logic [ID_W-1:0]       pix_id,
  input  logic [23:0]           pix_data,
  output logic                  out_valid,
  output logic                  out_is_rgb,
  output logic [7:0]            out_index,
  output logic [CMAP_W-1:0]     out_cmap,
  output logic [23:0]           out_rgb
);
  localparam int DEPTH  = 1 << ID_W;
  localparam int MODE_W = CMAP_W + 4;

  localparam logic [2:0] FMT_CI_SB  = 3'd0;
  localparam logic [2:0] FMT_CI_DB  = 3'd1;
  localparam logic [2:0] FMT_RGB24  = 3'd2;
  localparam logic [2:0] FMT_RGB12D = 3'd3;

  logic [MODE_W-1:0] mode_tab [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mode_tab[i] <= '0;
    end else if (cfg_we) begin
      mode_tab[cfg_id] <= cfg_mode;
    end
  end

  // stage 1: mode lookup
  logic              s1_valid;
  logic [23:0]       s1_pix;
  logic [MODE_W-1:0] s1_mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_pix   <= '0;
      s1_mode  <= '0;
    end else begin
      s1_valid <= pix_valid;
      s1_pix   <= pix_data;
      s1_mode  <= mode_tab[pix_id];
    end
  end

  wire [2:0]        s1_fmt   = s1_mode[2:0];
  wire              s1_front = s1_mode[3];
  wire [CMAP_W-1:0] s1_cmap  = s1_mode[MODE_W-1:4];

  wire [11:0] half12 = s1_front ? s1_pix[23:12] : s1_pix[11:0];
  wire [23:0] rgb_x  = {half12[11:8], half12[11:8], half12[7:4],
                        half12[7:4], half12[3:0], half12[3:0]};
  wire [7:0]  ci_db  = s1_front ? s1_pix[15:8] : s1_pix[7:0];

  logic              f_is_rgb;
  logic [7:0]        f_index;
  logic [CMAP_W-1:0] f_cmap;
  logic [23:0]       f_rgb;

  always_comb begin
    f_is_rgb = 1'b1;
    f_index  = '0;
    f_cmap   = '0;
    f_rgb    = '0;
    case (s1_fmt)
      FMT_CI_SB: begin
        f_is_rgb = 1'b0;
        f_index  = s1_pix[7:0];
        f_cmap   = s1_cmap;
      end
      FMT_CI_DB: begin
        f_is_rgb = 1'b0;
        f_index  = ci_db;
        f_cmap   = s1_cmap;
      end
      FMT_RGB24:  f_rgb = s1_pix;
      FMT_RGB12D: f_rgb = rgb_x;
      default:    f_rgb = '0;
    endcase
  end

  // stage 2: formatted output
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_is_rgb <= 1'b0;
      out_index  <= '0;
      out_cmap   <= '0;
      out_rgb    <= '0;
    end else begin
      out_valid  <= s1_valid;
      out_is_rgb <= f_is_rgb;
      out_index  <= f_index;
      out_cmap   <= f_cmap;
      out_rgb    <= f_rgb;
    end
  end

  assert_valid_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == $past(s1_valid));

  assert_rgb_clears_index_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_is_rgb) |-> (out_index == '0 && out_cmap == '0));

  assert_index_clears_rgb_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_is_rgb) |-> (out_rgb == '0));

  assert_nibble_replicated_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_valid && s1_fmt == FMT_RGB12D) |=>
      (out_is_rgb && out_rgb[23:20] == out_rgb[19:16] &&
       out_rgb[15:12] == out_rgb[11:8] && out_rgb[7:4] == out_rgb[3:0]));

  assert_reserved_blank_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_valid && s1_fmt[2]) |=> (out_is_rgb && out_rgb == '0));

  assert_true_colour_pass_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_valid && s1_fmt == FMT_RGB24) |=> (out_rgb == $past(s1_pix)));
endmodule

// File: tb/pixel_mode_mapper_test.sv
module pixel_mode_mapper_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [4:0]  cfg_id = '0;
  logic [6:0]  cfg_mode = '0;
  logic        pix_valid = 1'b0;
  logic [4:0]  pix_id = '0;
  logic [23:0] pix_data = '0;
  logic        out_valid, out_is_rgb;
  logic [7:0]  out_index;
  logic [2:0]  out_cmap;
  logic [23:0] out_rgb;

  always #10 clk = ~clk;

  pixel_mode_mapper uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_id(cfg_id), .cfg_mode(cfg_mode),
    .pix_valid(pix_valid), .pix_id(pix_id), .pix_data(pix_data),
    .out_valid(out_valid), .out_is_rgb(out_is_rgb), .out_index(out_index),
    .out_cmap(out_cmap), .out_rgb(out_rgb));

  int n_tests = 0;
  int n_fail  = 0;
  bit checking = 1'b0;
  logic [6:0]  model [32];
  logic [36:0] exp1 = '0, exp2 = '0;
  string       tag1 = "R2", tag2 = "R2";

  function automatic logic [36:0] predict(input logic [6:0] m, input logic [23:0] p, input logic v);
    logic [2:0]  fmt = m[2:0];
    logic        fr  = m[3];
    logic [11:0] h;
    logic [23:0] x;
    if (!v) return '0;
    h = fr ? p[23:12] : p[11:0];
    x = {h[11:8], h[11:8], h[7:4], h[7:4], h[3:0], h[3:0]};
    case (fmt)
      3'd0:    return {1'b1, 1'b0, p[7:0], m[6:4], 24'h0};
      3'd1:    return {1'b1, 1'b0, (fr ? p[15:8] : p[7:0]), m[6:4], 24'h0};
      3'd2:    return {1'b1, 1'b1, 8'h0, 3'h0, p};
      3'd3:    return {1'b1, 1'b1, 8'h0, 3'h0, x};
      default: return {1'b1, 1'b1, 8'h0, 3'h0, 24'h0};
    endcase
  endfunction

  function automatic string auto_tag(input logic [6:0] m, input logic v);
    if (!v) return "R2";
    case (m[2:0])
      3'd0: return "R5";
      3'd1: return "R6";
      3'd2: return "R7";
      3'd3: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic check_out();
    logic [36:0] got;
    if (!checking) return;
    got = {out_valid, out_is_rgb, out_index, out_cmap, out_rgb};
    n_tests++;
    if ((exp2[36] && got !== exp2) || (!exp2[36] && out_valid !== 1'b0)) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag2, got, exp2);
    end
    if (out_valid) begin
      // R10: the unused side of the output is zero
      n_tests++;
      if ((out_is_rgb && (out_index != 0 || out_cmap != 0)) || (!out_is_rgb && out_rgb != 0)) begin
        n_fail++;
        $display("FAIL R10: actual idx %h cmap %h rgb %h expected unused side zero",
                 out_index, out_cmap, out_rgb);
      end
    end
  endtask

  task automatic step(input logic we, input logic [4:0] wid, input logic [6:0] wm,
                      input logic v, input logic [4:0] id, input logic [23:0] px, input string tg);
    @(negedge clk);
    check_out();
    exp2 = exp1; tag2 = tag1;
    exp1 = predict(model[id], px, v);
    tag1 = (tg == "") ? auto_tag(model[id], v) : tg;
    if (we) model[wid] = wm;
    cfg_we = we; cfg_id = wid; cfg_mode = wm;
    pix_valid = v; pix_id = id; pix_data = px;
  endtask

  task automatic wr(input logic [4:0] wid, input logic [6:0] wm);
    step(1'b1, wid, wm, 1'b0, 5'd0, 24'h0, "R3");
  endtask

  task automatic px(input logic [4:0] id, input logic [23:0] d, input string tg);
    step(1'b0, 5'd0, 7'h0, 1'b1, id, d, tg);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL R2: actual run still going, expected finish before watchdog");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 32; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    n_tests++;
    if (out_valid !== 1'b0) begin
      n_fail++;
      $display("FAIL R1: actual out_valid %b expected 0 in reset", out_valid);
    end
    rst_n = 1'b1;
    checking = 1'b1;

    px(5'd7, 24'hABCDEF, "R1");          // reset table: CI8 index EF, cmap 0
    px(5'd20, 24'h123456, "R1");
    wr(5'd1, 7'h20);                      // fmt0, cmap 2
    wr(5'd2, 7'h59);                      // fmt1, front1, cmap 5
    wr(5'd3, 7'h02);                      // fmt2
    wr(5'd4, 7'h03);                      // fmt3 front0
    wr(5'd5, 7'h0B);                      // fmt3 front1
    wr(5'd6, 7'h05);                      // reserved
    wr(5'd31, 7'h71);                     // fmt1 front0 cmap7, top ID
    wr(5'd8, 7'h0A);                      // fmt2 with front set (ignored)
    wr(5'd10, 7'h48);                     // fmt0 with front set (ignored), cmap 4
    px(5'd1, 24'hABCDEF, "R5");
    px(5'd10, 24'hABCDEF, "R5");
    px(5'd2, 24'hABCDEF, "R6");
    px(5'd31, 24'hABCDEF, "R3");
    px(5'd3, 24'h123456, "R7");
    px(5'd8, 24'h123456, "R7");
    px(5'd4, 24'h123456, "R8");
    px(5'd5, 24'h123456, "R8");
    px(5'd6, 24'hFFFFFF, "R9");
    step(1'b0, 5'd0, 7'h0, 1'b0, 5'd3, 24'h777777, "R2");
    px(5'd3, 24'h0F0F0F, "R2");
    step(1'b1, 5'd9, 7'h02, 1'b1, 5'd9, 24'hC0FFEE, "R4");  // old entry (fmt0)
    px(5'd9, 24'hC0FFEE, "R4");                              // new entry (fmt2)
    step(1'b1, 5'd2, 7'h51, 1'b1, 5'd2, 24'h00AB12, "R4");  // still front 1
    px(5'd2, 24'h00AB12, "R4");                              // front 0 now

    for (int i = 0; i < 4000; i++) begin
      logic [4:0] id = 5'($urandom);
      logic       we = ($urandom % 10) < 3;
      logic [4:0] wid = ($urandom % 2) ? id : 5'($urandom);
      step(we, wid, 7'($urandom), ($urandom % 8) != 0, id, 24'($urandom), "");
    end
    repeat (3) step(1'b0, 5'd0, 7'h0, 1'b0, 5'd0, 24'h0, "R2");

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule